// File: doc/BRIEF.md
# Slack-Aware Switch Allocation Arbiter

This block chooses which input of a mesh router drives one output link in a given cycle. Up to five inputs (the four compass neighbours and the local core) may request together. Each request carries an 8-bit criticality tag, and the arbiter grants the single request with the highest criticality. Batch age decides first. Estimated slack decides next. A rotating pointer settles any tie that remains.

The arbiter keeps its own batch counter, which steps once every `BATCH_PERIOD` cycles. Age is measured as the distance from the current counter value back to the tag's batch. This keeps older work first even after the 3-bit batch number has wrapped, so no request can starve. The grant is registered, so it appears one clock after the requests that produced it.

Top module: `slack_sw_arbiter`

## Requirements
- R1: While reset is asserted and directly after it, `grantValid` is 0, `curBatch` is 0 and the tie pointer rests on port 0.
- R2: Tag field positions are: bits [7:5] batch, [4:3] count of predecessor misses, [2] no-miss flag, [1:0] hop slack. A grant appears on the clock edge that follows the requests. `grantOneHot` then has exactly one bit set, and that bit is the one selected by `grantIdx`.
- R3: A request whose batch is older wins over a younger one, whatever the slack fields of either request hold.
- R4: Batch age is `(curBatch - tagBatch) mod 8`, and a larger age means older. Batch 7 is therefore older than batch 0 while `curBatch` is 0 or 1.
- R5: Within one batch, the smaller predecessor-miss count wins.
- R6: When batch and predecessor count are equal, a no-miss flag of 0 beats 1. When that is also equal, the smaller hop slack wins.
- R7: When tags are equal, the first requester at or after the pointer (in cyclic order) wins. After each grant the pointer moves to the port just past the winner.
- R8: In a cycle with no grant, the pointer holds its value.
- R9: `curBatch` increments by one (mod 8) every `BATCH_PERIOD` cycles after reset.
- R10: With no request valid, no grant is issued on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Request per input port |
| reqTag | input | NUM_PORTS*8 | Packed tags; port p uses bits [8p+7:8p] |
| curBatch | output | 3 | Current batch counter |
| grantValid | output | 1 | A grant is issued this cycle |
| grantOneHot | output | NUM_PORTS | One-hot granted port |
| grantIdx | output | PORT_W | Index of granted port |

## Verification
The winner for a set of requests is due on the first rising edge after those requests are driven. The bench therefore drives at the falling edge and queues the expected winner, computed from the `curBatch` value seen at that moment. It then compares shortly after the following rising edge. `curBatch` is checked after every edge against a count of edges since reset divided by the period. The bench uses a short period so that the batch number wraps within the run.

// File: rtl/slack_sw_pkg.sv
`timescale 1ns/1ps
package slack_sw_pkg;
  localparam int TAG_W   = 8;
  localparam int BATCH_W = 3;

  typedef struct packed {
    logic [BATCH_W-1:0] batch;
    logic [1:0]         predMiss;
    logic               noMiss;
    logic [1:0]         hopSlack;
  } flitTag_t;

  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobe_t;

  // Lower cost = more critical. Older age maps to a smaller leading field.
  function automatic logic [TAG_W-1:0] tagCost(input flitTag_t tag,
                                               input logic [BATCH_W-1:0] cur);
    logic [BATCH_W-1:0] age;
    age = cur - tag.batch;
    return {~age, tag.predMiss, tag.noMiss, tag.hopSlack};
  endfunction
endpackage

// File: rtl/slack_sw_pick.sv
`timescale 1ns/1ps
module slack_sw_pick
  import slack_sw_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  localparam int PORT_W = $clog2(NUM_PORTS)
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       reqValid,
  input  logic [NUM_PORTS*TAG_W-1:0] reqTag,
  input  logic [BATCH_W-1:0]         curBatch,
  input  logic [PORT_W-1:0]          rrPtr,
  input  ctrlStrobe_t                strobes,
  output logic                       winnerValid,
  output logic [PORT_W-1:0]          winnerIdx,
  output logic                       grantValid,
  output logic [NUM_PORTS-1:0]       grantOneHot,
  output logic [PORT_W-1:0]          grantIdx
);
  logic [TAG_W-1:0] costArr [NUM_PORTS];

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_cost
      assign costArr[g] = tagCost(flitTag_t'(reqTag[g*TAG_W +: TAG_W]), curBatch);
    end
  endgenerate

  logic [TAG_W-1:0] bestCost;

  always_comb begin
    winnerValid = 1'b0;
    winnerIdx   = '0;
    bestCost    = '1;
    for (int k = 0; k < NUM_PORTS; k++) begin
      int p;
      p = int'(rrPtr) + k;
      if (p >= NUM_PORTS) p = p - NUM_PORTS;
      if (reqValid[p] && (!winnerValid || costArr[p] < bestCost)) begin
        winnerValid = 1'b1;
        winnerIdx   = PORT_W'(p);
        bestCost    = costArr[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      grantOneHot <= '0;
      grantIdx    <= '0;
    end else if (strobes.load) begin
      grantValid  <= 1'b1;
      grantOneHot <= NUM_PORTS'(1) << winnerIdx;
      grantIdx    <= winnerIdx;
    end else if (strobes.clear) begin
      grantValid  <= 1'b0;
      grantOneHot <= '0;
    end
  end

  // R2: a grant names exactly one port, consistent with its index
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($countones(grantOneHot) == 1 && ((grantOneHot >> grantIdx) & 1) == 1));
  // R10: a grant only goes to a port that requested on the previous edge
  a_r10_granted_requester: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((grantOneHot & $past(reqValid)) != '0));
  // R10: no requests, no grant
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|reqValid) |-> !grantValid);
endmodule

// File: rtl/slack_sw_ctrl.sv
`timescale 1ns/1ps
module slack_sw_ctrl
  import slack_sw_pkg::*;
#(
  parameter int NUM_PORTS    = 5,
  parameter int BATCH_PERIOD = 64,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int CNT_W  = $clog2(BATCH_PERIOD)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               winnerValid,
  input  logic [PORT_W-1:0]  winnerIdx,
  output logic [BATCH_W-1:0] curBatch,
  output logic [PORT_W-1:0]  rrPtr,
  output ctrlStrobe_t        strobes
);
  logic [CNT_W-1:0] cycleCnt;
  logic             batchTick;

  assign batchTick     = (cycleCnt == CNT_W'(BATCH_PERIOD - 1));
  assign strobes.load  = winnerValid;
  assign strobes.clear = !winnerValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
      curBatch <= '0;
    end else if (batchTick) begin
      cycleCnt <= '0;
      curBatch <= curBatch + 1'b1;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobes.load) begin
      rrPtr <= (winnerIdx == PORT_W'(NUM_PORTS - 1)) ? '0 : winnerIdx + 1'b1;
    end
  end

  // R8: pointer holds when nothing was granted
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(rrPtr));
  // R7: pointer always names a real port
  a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    rrPtr < PORT_W'(NUM_PORTS));
  // R9: batch number only ever steps by one
  a_r9_batch_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curBatch) |-> curBatch == $past(curBatch) + 1'b1);
endmodule

// File: rtl/slack_sw_arbiter.sv
`timescale 1ns/1ps
module slack_sw_arbiter
  import slack_sw_pkg::*;
#(
  parameter int NUM_PORTS    = 5,
  parameter int BATCH_PERIOD = 64,
  localparam int PORT_W = $clog2(NUM_PORTS)
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       reqValid,
  input  logic [NUM_PORTS*TAG_W-1:0] reqTag,
  output logic [BATCH_W-1:0]         curBatch,
  output logic                       grantValid,
  output logic [NUM_PORTS-1:0]       grantOneHot,
  output logic [PORT_W-1:0]          grantIdx
);
  logic              winnerValid;
  logic [PORT_W-1:0] winnerIdx;
  logic [PORT_W-1:0] rrPtr;
  ctrlStrobe_t       strobes;

  slack_sw_ctrl #(.NUM_PORTS(NUM_PORTS), .BATCH_PERIOD(BATCH_PERIOD)) i_ctrl (
    .clk(clk), .rstN(rstN), .winnerValid(winnerValid), .winnerIdx(winnerIdx),
    .curBatch(curBatch), .rrPtr(rrPtr), .strobes(strobes)
  );

  slack_sw_pick #(.NUM_PORTS(NUM_PORTS)) i_pick (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .curBatch(curBatch), .rrPtr(rrPtr), .strobes(strobes),
    .winnerValid(winnerValid), .winnerIdx(winnerIdx),
    .grantValid(grantValid), .grantOneHot(grantOneHot), .grantIdx(grantIdx)
  );
endmodule

// File: tb/test_slack_sw_arbiter.sv
`timescale 1ns/1ps
module test_slack_sw_arbiter;
  localparam int N = 5;
  localparam int T = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqValid = '0;
  logic [N*8-1:0] reqTag = '0;
  logic [2:0]   curBatch;
  logic         grantValid;
  logic [N-1:0] grantOneHot;
  logic [2:0]   grantIdx;

  int checks = 0;
  int failures = 0;
  int edgesSinceReset = 0;
  int modelPtr = 0;
  bit finished = 0;

  typedef struct { bit v; int idx; string req; } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  slack_sw_arbiter #(.NUM_PORTS(N), .BATCH_PERIOD(T)) i_slack_sw_arbiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .curBatch(curBatch), .grantValid(grantValid),
    .grantOneHot(grantOneHot), .grantIdx(grantIdx)
  );

  function automatic logic [7:0] mk(input logic [2:0] b, input int pred, input int nm, input int hop);
    return {b, 2'(pred), 1'(nm), 2'(hop)};
  endfunction

  // 1 when tag a is strictly more critical than tag b
  function automatic bit moreCritical(input logic [7:0] a, input logic [7:0] b, input logic [2:0] cur);
    logic [2:0] ageA, ageB;
    ageA = cur - a[7:5];
    ageB = cur - b[7:5];
    if (ageA != ageB) return ageA > ageB;
    if (a[4:3] != b[4:3]) return a[4:3] < b[4:3];
    if (a[2] != b[2]) return a[2] < b[2];
    return a[1:0] < b[1:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] v, input logic [7:0] t [N], input string req);
    expItem_t it;
    int best;
    @(negedge clk);
    reqValid = v;
    for (int p = 0; p < N; p++) reqTag[p*8 +: 8] = t[p];
    best = -1;
    for (int k = 0; k < N; k++) begin
      int p;
      p = (modelPtr + k) % N;
      if (v[p] && (best < 0 || moreCritical(t[p], t[best], curBatch))) best = p;
    end
    it.v = (best >= 0);
    it.idx = best;
    it.req = req;
    if (best >= 0) modelPtr = (best + 1) % N;
    expQ.push_back(it);
  endtask

  task automatic idle(input string req);
    logic [7:0] z [N];
    for (int p = 0; p < N; p++) z[p] = '0;
    drive('0, z, req);
  endtask

  // monitor: compares queued expectations shortly after each edge
  always @(posedge clk) begin
    if (rstN) edgesSinceReset++;
    #5;
    if (rstN && !finished) begin
      check("R9 batch count", int'(curBatch), (edgesSinceReset / T) % 8);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.req, " grantValid"}, int'(grantValid), int'(it.v));
        if (it.v) begin
          check({it.req, " grantIdx"}, int'(grantIdx), it.idx);
          check("R2 one-hot matches index", int'(grantOneHot), 1 << it.idx);
        end else begin
          check({it.req, " no one-hot"}, int'(grantOneHot), 0);
        end
      end
    end
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] t [N];
    logic [2:0] c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset grantValid", int'(grantValid), 0);
    check("R1 reset curBatch", int'(curBatch), 0);
    rstN = 1'b1;

    // R7: equal tags rotate from the pointer, starting at port 0 (R1)
    for (int p = 0; p < N; p++) t[p] = mk(curBatch, 1, 1, 1);
    drive('1, t, "R1 R7 tie from port0");
    for (int p = 0; p < N; p++) t[p] = mk(curBatch, 1, 1, 1);
    drive('1, t, "R7 tie rotates");
    for (int p = 0; p < N; p++) t[p] = mk(curBatch, 1, 1, 1);
    drive('1, t, "R7 tie rotates again");
    idle("R10 no request");
    for (int p = 0; p < N; p++) t[p] = mk(curBatch, 2, 0, 2);
    drive('1, t, "R8 pointer held over idle");

    // R3: older batch beats better slack
    c = curBatch;
    for (int p = 0; p < N; p++) t[p] = '0;
    t[0] = mk(c - 3'd1, 3, 1, 3);
    t[4] = mk(c, 0, 0, 0);
    drive(5'b10001, t, "R3 older batch wins");

    // R5: predecessor count
    c = curBatch;
    t[1] = mk(c, 1, 1, 3);
    t[2] = mk(c, 2, 0, 0);
    drive(5'b00110, t, "R5 fewer predecessor misses");

    // R6: no-miss flag then hop slack
    c = curBatch;
    t[2] = mk(c, 1, 0, 3);
    t[3] = mk(c, 1, 1, 0);
    drive(5'b01100, t, "R6 miss flag decides");
    c = curBatch;
    t[0] = mk(c, 2, 1, 3);
    t[3] = mk(c, 2, 1, 1);
    drive(5'b01001, t, "R6 hop slack decides");

    // R4: wraparound, wait until the counter reads 1, then 0
    while (curBatch != 3'd1) idle("R10 idle wait");
    t[0] = mk(3'd0, 0, 0, 0);
    t[1] = mk(3'd7, 3, 1, 3);
    drive(5'b00011, t, "R4 batch 7 older at cur 1");
    while (curBatch != 3'd0) idle("R10 idle wait");
    t[0] = mk(3'd0, 0, 0, 0);
    t[1] = mk(3'd7, 3, 1, 3);
    drive(5'b00011, t, "R4 batch 7 older at cur 0");

    repeat (3) idle("R10 trailing idle");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule